// File: doc/BRIEF.md
# Per-Master Command Reorder Queue

This block keeps the outstanding memory commands of a single bus master in a short, age-ordered queue. Every cycle it offers exactly one of them as the master's candidate to a downstream arbiter, using a valid/ready handshake. When the arbiter accepts the candidate, that entry leaves the queue in the same clock edge. Each command carries three things: a read/write flag, a byte address and a 3-bit urgency value, where a larger value is more urgent.

The normal choice is the oldest queued command. To keep read latency low, the oldest queued read may jump ahead of the writes queued before it. It may do so only if two conditions hold against every one of those older writes:

- the read lies in a different 2048-byte block, and
- its urgency is at least as high.

If either condition fails against any older write, the oldest entry is offered instead. Reads never pass other reads, and writes never pass anything. An entry can be removed from the middle of the queue, and the entries left behind keep their relative age.

Enqueue and acceptance may happen in the same cycle. When every slot is occupied, a full flag is raised and new commands are not taken.

Top module: `cmd_reorder_queue`

## Requirements
- R1: After reset the queue is empty: `cand_valid` is 0 and `q_full` is 0.
- R2: With no eligible read bypass, the candidate is the oldest queued command, so commands leave in arrival order.
- R3: The oldest queued read is offered ahead of all older writes when, against each of them, its block address (`addr[ADDR_W-1:11]`) differs and its urgency is greater than or equal.
- R4: A read whose block address equals that of any older queued write is not advanced; the oldest entry is offered.
- R5: A read whose urgency is lower than that of any older queued write is not advanced; the oldest entry is offered.
- R6: The bypass condition is evaluated against every older write. A single failing write blocks the bypass, even when the other writes would allow it.
- R7: Only the oldest queued read can be advanced. A younger read is never offered ahead of an older read.
- R8: With `DEPTH` entries queued, `q_full` is 1 and an offered enqueue is ignored: the queue contents are unchanged.
- R9: When an entry is removed from the middle of the queue, the remaining entries keep their relative age order.
- R10: An enqueue and an acceptance in the same cycle both take effect. The new entry becomes the youngest, and the removed entry is chosen from the contents held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Offer a new command; taken when `q_full` is 0 |
| enq_is_rd | input | 1 | New command is a read (1) or a write (0) |
| enq_addr | input | ADDR_W | Byte address of the new command |
| enq_prio | input | 3 | Urgency of the new command, larger is more urgent |
| q_full | output | 1 | All DEPTH slots occupied |
| cand_valid | output | 1 | A candidate command is offered |
| cand_is_rd | output | 1 | Candidate is a read |
| cand_addr | output | ADDR_W | Candidate byte address |
| cand_prio | output | 3 | Candidate urgency |
| cand_ready | input | 1 | Arbiter accepts the candidate this cycle |

## Verification
Insertion and removal can fall in the same cycle. This is the case most likely to corrupt the age order, because the compaction shift and the append slot must agree on one position. The bench provokes it by raising `enq_valid` and `cand_ready` together, both with a head removal and while a bypassing read is taken out of the middle of the queue. The scoreboard judges it from the order in which all later candidates emerge, compared against an independent queue model.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int unsigned CMDQ_PRIO_W  = 3;
  localparam int unsigned CMDQ_BLK_LSB = 11;

  typedef logic [CMDQ_PRIO_W-1:0] cmdq_prio_t;

  // Urgency half of the bypass rule: a read may pass a write of equal or
  // lower urgency.
  function automatic logic prio_allows(cmdq_prio_t rd_prio, cmdq_prio_t wr_prio);
    return rd_prio >= wr_prio;
  endfunction
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_rd,
  input  logic [ADDR_W-1:0] push_addr,
  input  cmdq_prio_t        push_prio,
  input  logic              pop,
  input  logic [IDX_W-1:0]  pop_idx,
  output logic              e_vld  [DEPTH],
  output logic              e_rd   [DEPTH],
  output logic [ADDR_W-1:0] e_addr [DEPTH],
  output cmdq_prio_t        e_prio [DEPTH],
  output logic [CNT_W-1:0]  count
);
  // Slot 0 holds the oldest entry. The slot index is the entry's age.
  logic              rd_q   [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  cmdq_prio_t        prio_q [DEPTH];
  logic              rd_d   [DEPTH];
  logic [ADDR_W-1:0] addr_d [DEPTH];
  cmdq_prio_t        prio_d [DEPTH];
  logic [CNT_W-1:0]  count_d;

  always_comb begin
    int kept;
    kept = int'(count) - (pop ? 1 : 0);
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      src = (pop && i >= int'(pop_idx)) ? i + 1 : i;
      rd_d[i]   = rd_q[i];
      addr_d[i] = addr_q[i];
      prio_d[i] = prio_q[i];
      if (push && i == kept) begin
        rd_d[i]   = push_rd;
        addr_d[i] = push_addr;
        prio_d[i] = push_prio;
      end else if (src < DEPTH) begin
        rd_d[i]   = rd_q[src];
        addr_d[i] = addr_q[src];
        prio_d[i] = prio_q[src];
      end
    end
    count_d = CNT_W'(kept + (push ? 1 : 0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      rd_q[i]   <= rd_d[i];
      addr_q[i] <= addr_d[i];
      prio_q[i] <= prio_d[i];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign e_vld[g]  = (CNT_W'(g) < count);
    assign e_rd[g]   = rd_q[g];
    assign e_addr[g] = addr_q[g];
    assign e_prio[g] = prio_q[g];
  end
endmodule

// File: rtl/cmdq_pick.sv
module cmdq_pick
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              e_vld  [DEPTH],
  input  logic              e_rd   [DEPTH],
  input  logic [ADDR_W-1:0] e_addr [DEPTH],
  input  cmdq_prio_t        e_prio [DEPTH],
  output logic              sel_valid,
  output logic [IDX_W-1:0]  sel_idx,
  output logic              bypass
);
  function automatic logic [ADDR_W-CMDQ_BLK_LSB-1:0] blk_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:CMDQ_BLK_LSB];
  endfunction

  logic             rd_found;
  logic [IDX_W-1:0] rd_idx;
  logic             blocked;

  // Oldest queued read.
  always_comb begin
    rd_found = 1'b0;
    rd_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!rd_found && e_vld[i] && e_rd[i]) begin
        rd_found = 1'b1;
        rd_idx   = IDX_W'(i);
      end
    end
  end

  // Every entry older than that read is a write; each one must permit it.
  always_comb begin
    blocked = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (e_vld[j] && IDX_W'(j) < rd_idx) begin
        if (blk_of(e_addr[j]) == blk_of(e_addr[rd_idx]) ||
            !prio_allows(e_prio[rd_idx], e_prio[j]))
          blocked = 1'b1;
      end
    end
  end

  assign bypass    = rd_found && !blocked && (rd_idx != '0);
  assign sel_idx   = bypass ? rd_idx : '0;
  assign sel_valid = e_vld[0];
endmodule

// File: rtl/cmd_reorder_queue.sv
module cmd_reorder_queue
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enq_valid,
  input  logic                   enq_is_rd,
  input  logic [ADDR_W-1:0]      enq_addr,
  input  logic [CMDQ_PRIO_W-1:0] enq_prio,
  output logic                   q_full,
  output logic                   cand_valid,
  output logic                   cand_is_rd,
  output logic [ADDR_W-1:0]      cand_addr,
  output logic [CMDQ_PRIO_W-1:0] cand_prio,
  input  logic                   cand_ready
);
  logic              e_vld  [DEPTH];
  logic              e_rd   [DEPTH];
  logic [ADDR_W-1:0] e_addr [DEPTH];
  cmdq_prio_t        e_prio [DEPTH];
  logic [CNT_W-1:0]  count;
  logic [IDX_W-1:0]  sel_idx;
  logic              sel_valid;

  // Named internal events, observed by the bound checker.
  logic              bypass_sel;
  logic              push_ev;
  logic              pop_ev;
  logic              head_is_rd;
  logic [ADDR_W-1:0] head_addr;
  cmdq_prio_t        head_prio;

  assign q_full  = (count == CNT_W'(DEPTH));
  assign push_ev = enq_valid && !q_full;
  assign pop_ev  = cand_valid && cand_ready;

  cmdq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_ev),
    .push_rd   (enq_is_rd),
    .push_addr (enq_addr),
    .push_prio (enq_prio),
    .pop       (pop_ev),
    .pop_idx   (sel_idx),
    .e_vld     (e_vld),
    .e_rd      (e_rd),
    .e_addr    (e_addr),
    .e_prio    (e_prio),
    .count     (count)
  );

  cmdq_pick #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_pick (
    .e_vld     (e_vld),
    .e_rd      (e_rd),
    .e_addr    (e_addr),
    .e_prio    (e_prio),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .bypass    (bypass_sel)
  );

  assign head_is_rd = e_rd[0];
  assign head_addr  = e_addr[0];
  assign head_prio  = e_prio[0];

  assign cand_valid = sel_valid;
  assign cand_is_rd = e_rd[sel_idx];
  assign cand_addr  = e_addr[sel_idx];
  assign cand_prio  = e_prio[sel_idx];
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              q_full,
  input logic              cand_valid,
  input logic              cand_ready,
  input logic              cand_is_rd,
  input logic [ADDR_W-1:0] cand_addr,
  input logic [2:0]        cand_prio,
  input logic              bypass_sel,
  input logic              head_is_rd,
  input logic [ADDR_W-1:0] head_addr,
  input logic [2:0]        head_prio
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cand_valid && !q_full));

  p_bypass_is_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_sel |-> (cand_valid && cand_is_rd && !head_is_rd));

  p_bypass_other_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_sel |-> (cand_addr[ADDR_W-1:11] != head_addr[ADDR_W-1:11]));

  p_bypass_urgency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_sel |-> (cand_prio >= head_prio));

  p_read_head_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && head_is_rd) |-> (!bypass_sel && cand_addr == head_addr));

  p_full_offers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> cand_valid);

  p_full_no_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !(cand_valid && cand_ready)) |=> q_full);
endmodule

bind cmd_reorder_queue cmdq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .q_full     (q_full),
  .cand_valid (cand_valid),
  .cand_ready (cand_ready),
  .cand_is_rd (cand_is_rd),
  .cand_addr  (cand_addr),
  .cand_prio  (cand_prio),
  .bypass_sel (bypass_sel),
  .head_is_rd (head_is_rd),
  .head_addr  (head_addr),
  .head_prio  (head_prio)
);

// File: tb/sim_cmd_reorder_queue.sv
`timescale 1ns/1ps
module sim_cmd_reorder_queue;
  localparam int DEPTH = 8;

  logic        clk = 0, rst_n = 0;
  logic        enq_valid = 0, enq_is_rd = 0, cand_ready = 0;
  logic [31:0] enq_addr = '0;
  logic [2:0]  enq_prio = '0;
  logic        q_full, cand_valid, cand_is_rd;
  logic [31:0] cand_addr;
  logic [2:0]  cand_prio;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    bit        rd;
    bit [31:0] addr;
    bit [2:0]  prio;
    string     tag;
  } item_t;

  item_t mq[$];     // model of queue contents, index 0 oldest
  item_t exp_q[$];  // scoreboard of expected accepted commands

  always #2 clk = ~clk;

  cmd_reorder_queue #(.DEPTH(DEPTH), .ADDR_W(32)) u0 (
    .clk, .rst_n, .enq_valid, .enq_is_rd, .enq_addr, .enq_prio,
    .q_full, .cand_valid, .cand_is_rd, .cand_addr, .cand_prio, .cand_ready
  );

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Independent statement of the selection rule.
  function automatic int model_pick();
    int r = -1;
    for (int k = 0; k < mq.size(); k++)
      if (mq[k].rd) begin r = k; break; end
    if (r <= 0) return 0;
    for (int j = 0; j < r; j++)
      if (mq[j].addr[31:11] == mq[r].addr[31:11] || mq[r].prio < mq[j].prio)
        return 0;
    return r;
  endfunction

  task automatic take_into_sb(string tag);
    int idx;
    item_t it;
    idx = model_pick();
    it = mq[idx];
    it.tag = tag;
    exp_q.push_back(it);
    mq.delete(idx);
  endtask

  task automatic enq(bit rd, bit [31:0] a, bit [2:0] p);
    @(posedge clk); #1;
    enq_valid = 1; enq_is_rd = rd; enq_addr = a; enq_prio = p;
    if (mq.size() < DEPTH) mq.push_back('{rd, a, p, ""});
    @(posedge clk); #1;
    enq_valid = 0;
  endtask

  task automatic deq(string tag);
    @(posedge clk); #1;
    take_into_sb(tag);
    cand_ready = 1;
    @(posedge clk); #1;
    cand_ready = 0;
  endtask

  task automatic enq_deq(bit rd, bit [31:0] a, bit [2:0] p, string tag);
    @(posedge clk); #1;
    take_into_sb(tag);
    mq.push_back('{rd, a, p, ""});
    enq_valid = 1; enq_is_rd = rd; enq_addr = a; enq_prio = p;
    cand_ready = 1;
    @(posedge clk); #1;
    enq_valid = 0; cand_ready = 0;
  endtask

  task automatic drain(int n, string tag);
    for (int k = 0; k < n; k++) deq(tag);
  endtask

  // Monitor: each accepted candidate is compared with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && cand_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "SB", "unexpected acceptance", 1, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(cand_valid == 1'b1, e.tag, "cand_valid", cand_valid, 1);
        check(cand_is_rd == e.rd, e.tag, "cand_is_rd", cand_is_rd, e.rd);
        check(cand_addr == e.addr, e.tag, "cand_addr", cand_addr, e.addr);
        check(cand_prio == e.prio, e.tag, "cand_prio", cand_prio, e.prio);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    check(0, "WDOG", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(cand_valid == 0, "R1", "cand_valid after reset", cand_valid, 0);
    check(q_full == 0, "R1", "q_full after reset", q_full, 0);

    // R2: writes only, arrival order
    enq(0, 32'h0000_0000, 3'd1);
    enq(0, 32'h0000_0800, 3'd7);
    enq(0, 32'h0000_1000, 3'd0);
    drain(3, "R2");

    // R3: read passes two writes in other blocks with lower or equal urgency
    enq(0, 32'h0000_0000, 3'd2);
    enq(0, 32'h0000_0800, 3'd3);
    enq(1, 32'h0000_2800, 3'd3);
    deq("R3");
    drain(2, "R2");

    // R4: same block blocks the bypass
    enq(0, 32'h0000_1000, 3'd0);
    enq(1, 32'h0000_1010, 3'd7);
    drain(2, "R4");

    // R5: lower urgency blocks the bypass
    enq(0, 32'h0000_0000, 3'd5);
    enq(1, 32'h0000_4000, 3'd4);
    drain(2, "R5");

    // R6: one failing older write is enough to block
    enq(0, 32'h0000_0000, 3'd1);
    enq(0, 32'h0000_8000, 3'd6);
    enq(1, 32'h0001_0000, 3'd5);
    drain(3, "R6");

    // R7: a younger eligible read does not pass an older blocked read
    enq(0, 32'h0000_0000, 3'd0);
    enq(1, 32'h0000_0004, 3'd7);
    enq(1, 32'h0000_4000, 3'd7);
    drain(3, "R7");

    // R9: read removed from the middle, writes keep their order
    enq(0, 32'h0000_0000, 3'd0);
    enq(0, 32'h0000_0800, 3'd0);
    enq(1, 32'h0000_5000, 3'd6);
    enq(0, 32'h0000_1000, 3'd0);
    enq(0, 32'h0000_1800, 3'd0);
    deq("R9");
    drain(4, "R9");

    // R10: simultaneous enqueue and acceptance at the head
    enq(0, 32'h0000_0000, 3'd2);
    enq_deq(1, 32'h0000_6000, 3'd7, "R10");
    enq(0, 32'h0000_7000, 3'd7);
    drain(2, "R10");

    // R10: simultaneous enqueue and mid-queue bypass removal
    enq(0, 32'h0000_0000, 3'd0);
    enq(1, 32'h0000_3000, 3'd4);
    enq(0, 32'h0000_0800, 3'd1);
    enq_deq(0, 32'h0000_0c00, 3'd2, "R10");
    drain(3, "R10");

    // R8: fill, refuse an extra enqueue, drain in order
    for (int k = 0; k < DEPTH; k++) enq(0, 32'h0001_0000 + 32'(k) * 32'h40, 3'(k));
    @(negedge clk);
    check(q_full == 1, "R8", "q_full at depth", q_full, 1);
    enq(1, 32'h00ff_0000, 3'd7);
    @(negedge clk);
    check(q_full == 1, "R8", "q_full after refused enqueue", q_full, 1);
    drain(DEPTH, "R8");
    @(negedge clk);
    check(cand_valid == 0, "R8", "queue empty after drain", cand_valid, 0);
    check(q_full == 0, "R8", "q_full after drain", q_full, 0);

    @(negedge clk);
    check(exp_q.size() == 0, "SB", "scoreboard leftovers", exp_q.size(), 0);
    finish_run();
  end
endmodule